// File: doc/BRIEF.md
# Match-Capture Counter Timer with Single-Edge PWM

This block is a free-running up counter with four compare slots and one capture input. Software sets it up through a write-only register port. The counter steps on every clock while it is enabled, or it steps on chosen transitions of the capture input, which are first synchronized into the timer clock. When the counter value equals a compare slot on a counting step, that slot can do four things: post an interrupt, return the counter to zero, halt counting, and act on its own output pin.

The capture input copies the counter into a holding register on a chosen transition, and it can also post an interrupt. A pulse-width mode turns the lowest three compare slots into single-edge PWM sources. In this mode the top slot sets the period and restarts the counter. The counter, the captured value and the pending interrupt bits are visible on output ports, so the state can be watched without a read path.

Top module: `mctimer`

## Requirements
- R1: After synchronous reset, `tc_o`, `cap_o`, `pend_o`, `irq_o` and `match_o` are all zero and every configuration register is zero.
- R2: Control register at address 0: bit 0 enables counting and bit 1 holds the counter. Source register at address 1, bits [1:0], with code 00 selecting the clock. With the enable bit set, the hold bit clear and code 00, `tc_o` rises by one on every clock. With the enable bit clear, `tc_o` stays constant.
- R3: While control bit 1 is set, `tc_o` is forced to zero, whatever the enable bit holds.
- R4: Source codes 01, 10 and 11 make the counter step once per rising edge, per falling edge, or per edge of either polarity on `cap_in`. Each edge passes through a two-flop synchronizer and an edge detector first.
- R5: A compare event for slot i (compare value at address 8+i) happens on a counting step taken while `tc_o` equals that value. If bit 3i of the slot-control register (address 3) is set, the event sets `pend_o[i]`. If that bit is clear, the event leaves `pend_o[i]` alone.
- R6: If bit 3i+1 of address 3 is set, a compare event for slot i loads zero into the counter instead of the incremented value.
- R7: If bit 3i+2 of address 3 is set, a compare event for slot i leaves the counter at its current value and clears the enable bit.
- R8: Capture register at address 2: bit 0 selects rising edges and bit 1 selects falling edges. On a selected synchronized edge of `cap_in`, `cap_o` takes the value `tc_o` had in the cycle before its update. This falls three clocks after the input changes.
- R9: If bit 2 of address 2 is set, every capture also sets `pend_o[4]`.
- R10: Output action register at address 4: bits [2i+1:2i] choose slot i's pin action on a compare event. 00 keeps the pin, 01 drives it low, 10 drives it high and 11 inverts it. A write to address 4 also loads bits [8+i] directly into output pin i, and the load takes priority over a compare event in the same cycle.
- R11: PWM register at address 5: bit i (for i<3) hands `match_o[i]` to PWM logic. While any of these bits is set, a compare event on slot 3 restarts the counter at zero. A PWM output reads 1 exactly when `tc_o` is at or above its compare value. A value of 0 therefore holds it high, and a value above the period holds it low.
- R12: Writing ones to address 6 clears the matching `pend_o` bits. A set in the same cycle wins over the clear. `irq_o` is high whenever any pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| cap_in | input | 1 | Asynchronous capture / count input |
| match_o | output | 4 | Compare output pins |
| irq_o | output | 1 | OR of all pending bits |
| tc_o | output | 32 | Current counter value |
| cap_o | output | 32 | Last captured counter value |
| pend_o | output | 5 | Pending interrupt bits, slots 0-3 then capture |

## Verification
A software clear of a pending bit and a fresh compare event for that same slot can reach the interrupt register on the same clock edge. The bench forces this by counting cycles from the enable write. It issues the clear on exactly the edge where the counter sits on the compare value and the slot's stop action also fires. It judges the result by requiring that `pend_o[0]` is still set afterwards, that the counter is frozen at the compare value, and that a later clear with no competing event empties the register and drops `irq_o`.

// File: rtl/mct_pkg.sv
package mct_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_SRC  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CAPC = 4'd2;
    localparam logic [ADDR_W-1:0] A_SLOT = 4'd3;
    localparam logic [ADDR_W-1:0] A_PINS = 4'd4;
    localparam logic [ADDR_W-1:0] A_PWM  = 4'd5;
    localparam logic [ADDR_W-1:0] A_IRQ  = 4'd6;
    localparam logic [ADDR_W-1:0] A_CMP0 = 4'd8;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'b00,
        SRC_RISE = 2'b01,
        SRC_FALL = 2'b10,
        SRC_BOTH = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_FLIP = 2'b11
    } act_e;

    // slot control field, LSB first: irq, zero, stop
    typedef struct packed {
        logic stop;
        logic zero;
        logic irq;
    } slot_t;

    // capture control field, LSB first: rise, fall, irq
    typedef struct packed {
        logic irq;
        logic fall;
        logic rise;
    } capc_t;

    function automatic logic pin_next(act_e a, logic cur);
        case (a)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_FLIP: return ~cur;
            default:  return cur;
        endcase
    endfunction

    function automatic logic src_step(src_e s, logic r, logic f);
        case (s)
            SRC_CLK:  return 1'b1;
            SRC_RISE: return r;
            SRC_FALL: return f;
            default:  return r | f;
        endcase
    endfunction

endpackage

// File: rtl/mct_edge.sv
module mct_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;

endmodule

// File: rtl/mct_regs.sv
module mct_regs
    import mct_pkg::*;
#(
    parameter int TW = 32,
    parameter int NM = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [TW-1:0]          wr_data,
    input  logic                   stop_req,
    output logic                   en,
    output logic                   hold,
    output src_e                   src,
    output capc_t                  capc,
    output slot_t [NM-1:0]         slot,
    output act_e  [NM-1:0]         act,
    output logic  [NM-2:0]         pwm_en,
    output logic  [NM-1:0][TW-1:0] cmp,
    output logic                   pin_ld,
    output logic  [NM-1:0]         pin_val,
    output logic  [NM:0]           pend_clr
);
    logic hit_ctrl;
    assign hit_ctrl = wr_en && (wr_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            hold   <= 1'b0;
            src    <= SRC_CLK;
            capc   <= '0;
            slot   <= '0;
            act    <= {NM{ACT_KEEP}};
            pwm_en <= '0;
            cmp    <= '0;
        end else begin
            if (hit_ctrl) begin
                en   <= wr_data[0];
                hold <= wr_data[1];
            end else if (stop_req) begin
                en <= 1'b0;
            end
            if (wr_en && wr_addr == A_SRC)  src    <= src_e'(wr_data[1:0]);
            if (wr_en && wr_addr == A_CAPC) capc   <= capc_t'(wr_data[2:0]);
            if (wr_en && wr_addr == A_PWM)  pwm_en <= wr_data[NM-2:0];
            for (int i = 0; i < NM; i++) begin
                if (wr_en && wr_addr == A_SLOT) slot[i] <= slot_t'(wr_data[3*i +: 3]);
                if (wr_en && wr_addr == A_PINS) act[i]  <= act_e'(wr_data[2*i +: 2]);
                if (wr_en && wr_addr == A_CMP0 + ADDR_W'(i)) cmp[i] <= wr_data;
            end
        end
    end

    assign pin_ld   = wr_en && (wr_addr == A_PINS);
    assign pin_val  = wr_data[2*NM +: NM];
    assign pend_clr = (wr_en && wr_addr == A_IRQ) ? wr_data[NM:0] : '0;

    // R7
    stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !hit_ctrl) |=> !en);

endmodule

// File: rtl/mct_counter.sv
module mct_counter
    import mct_pkg::*;
#(
    parameter int TW = 32,
    parameter int NM = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   hold,
    input  src_e                   src,
    input  logic                   rise,
    input  logic                   fall,
    input  logic                   cap_rise,
    input  logic                   cap_fall,
    input  logic [NM-1:0]          zero_m,
    input  logic [NM-1:0]          stop_m,
    input  logic                   pwm_on,
    input  logic [NM-1:0][TW-1:0]  cmp,
    output logic [TW-1:0]          tc_q,
    output logic [TW-1:0]          tc_nxt,
    output logic [TW-1:0]          cap_q,
    output logic [NM-1:0]          mev,
    output logic                   cev,
    output logic                   stop_req
);
    logic [NM-1:0] eq;
    logic          step;
    logic          zero_go;

    always_comb begin
        for (int i = 0; i < NM; i++) eq[i] = (tc_q == cmp[i]);
    end

    assign step     = en && !hold && src_step(src, rise, fall);
    assign mev      = step ? eq : '0;
    assign zero_go  = (|(mev & zero_m)) | (pwm_on & mev[NM-1]);
    assign stop_req = |(mev & stop_m);
    assign cev      = (cap_rise & rise) | (cap_fall & fall);

    always_comb begin
        if (hold || zero_go)        tc_nxt = '0;
        else if (stop_req || !step) tc_nxt = tc_q;
        else                        tc_nxt = tc_q + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_q  <= '0;
            cap_q <= '0;
        end else begin
            tc_q <= tc_nxt;
            if (cev) cap_q <= tc_q;
        end
    end

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> tc_q == '0);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !hold && src == SRC_CLK && mev == '0) |=> tc_q == $past(tc_q) + TW'(1));

    // R6
    match_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((mev & zero_m) != '0) |=> tc_q == '0);

    // R8
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        cev |=> cap_q == $past(tc_q));

endmodule

// File: rtl/mct_outputs.sv
module mct_outputs
    import mct_pkg::*;
#(
    parameter int TW = 32,
    parameter int NM = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NM-1:0]          mev,
    input  logic                   cev,
    input  logic [NM-1:0]          irq_m,
    input  logic                   cap_irq,
    input  act_e [NM-1:0]          act,
    input  logic [NM-2:0]          pwm_en,
    input  logic [NM-2:0][TW-1:0]  cmp_lo,
    input  logic [TW-1:0]          tc_nxt,
    input  logic                   pin_ld,
    input  logic [NM-1:0]          pin_val,
    input  logic [NM:0]            pend_clr,
    output logic [NM-1:0]          match_o,
    output logic [NM:0]            pend,
    output logic                   irq
);
    logic [NM-1:0] pin_q;
    logic [NM-2:0] pwm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= '0;
            pwm_q <= '0;
            pend  <= '0;
        end else begin
            for (int i = 0; i < NM; i++) begin
                if (pin_ld)      pin_q[i] <= pin_val[i];
                else if (mev[i]) pin_q[i] <= pin_next(act[i], pin_q[i]);
                pend[i] <= (pend[i] & ~pend_clr[i]) | (mev[i] & irq_m[i]);
            end
            for (int i = 0; i < NM-1; i++) pwm_q[i] <= (tc_nxt >= cmp_lo[i]);
            pend[NM] <= (pend[NM] & ~pend_clr[NM]) | (cev & cap_irq);
        end
    end

    genvar g;
    generate
        for (g = 0; g < NM; g++) begin : g_pin
            if (g < NM-1) begin : g_pwm
                assign match_o[g] = pwm_en[g] ? pwm_q[g] : pin_q[g];
            end else begin : g_ext
                assign match_o[g] = pin_q[g];
            end

            // R12
            pend_set_chk: assert property (@(posedge clk) disable iff (rst)
                (mev[g] && irq_m[g]) |=> pend[g]);

            // R10
            pin_keep_chk: assert property (@(posedge clk) disable iff (rst)
                (!pin_ld && !mev[g]) |=> pin_q[g] == $past(pin_q[g]));
        end
    endgenerate

    assign irq = |pend;

endmodule

// File: rtl/mctimer.sv
module mctimer
    import mct_pkg::*;
#(
    parameter int TW = 32,
    parameter int NM = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TW-1:0]     wr_data,
    input  logic              cap_in,
    output logic [NM-1:0]     match_o,
    output logic              irq_o,
    output logic [TW-1:0]     tc_o,
    output logic [TW-1:0]     cap_o,
    output logic [NM:0]       pend_o
);
    logic                  en, hold, stop_req, rise, fall, cev, pin_ld;
    src_e                  src;
    capc_t                 capc;
    slot_t [NM-1:0]        slot;
    act_e  [NM-1:0]        act;
    logic  [NM-2:0]        pwm_en;
    logic  [NM-1:0][TW-1:0] cmp;
    logic  [NM-1:0]        pin_val, mev, irq_m, zero_m, stop_m;
    logic  [NM:0]          pend_clr;
    logic  [TW-1:0]        tc_nxt;

    genvar g;
    generate
        for (g = 0; g < NM; g++) begin : g_mask
            assign irq_m[g]  = slot[g].irq;
            assign zero_m[g] = slot[g].zero;
            assign stop_m[g] = slot[g].stop;
        end
    endgenerate

    mct_regs #(.TW(TW), .NM(NM)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stop_req(stop_req), .en(en), .hold(hold), .src(src), .capc(capc),
        .slot(slot), .act(act), .pwm_en(pwm_en), .cmp(cmp),
        .pin_ld(pin_ld), .pin_val(pin_val), .pend_clr(pend_clr)
    );

    mct_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .din(cap_in), .rise(rise), .fall(fall)
    );

    mct_counter #(.TW(TW), .NM(NM)) u_cnt (
        .clk(clk), .rst(rst), .en(en), .hold(hold), .src(src),
        .rise(rise), .fall(fall), .cap_rise(capc.rise), .cap_fall(capc.fall),
        .zero_m(zero_m), .stop_m(stop_m), .pwm_on(|pwm_en), .cmp(cmp),
        .tc_q(tc_o), .tc_nxt(tc_nxt), .cap_q(cap_o), .mev(mev), .cev(cev),
        .stop_req(stop_req)
    );

    mct_outputs #(.TW(TW), .NM(NM)) u_out (
        .clk(clk), .rst(rst), .mev(mev), .cev(cev), .irq_m(irq_m),
        .cap_irq(capc.irq), .act(act), .pwm_en(pwm_en), .cmp_lo(cmp[NM-2:0]),
        .tc_nxt(tc_nxt), .pin_ld(pin_ld), .pin_val(pin_val), .pend_clr(pend_clr),
        .match_o(match_o), .pend(pend_o), .irq(irq_o)
    );

endmodule

// File: tb/sim_mctimer.sv
module sim_mctimer;
    localparam logic [3:0] A_CTRL = 4'd0, A_SRC = 4'd1, A_CAPC = 4'd2, A_SLOT = 4'd3;
    localparam logic [3:0] A_PINS = 4'd4, A_PWM = 4'd5, A_IRQ = 4'd6, A_CMP0 = 4'd8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        cap_in = 1'b0;
    logic [3:0]  match_o;
    logic        irq_o;
    logic [31:0] tc_o, cap_o;
    logic [4:0]  pend_o;

    int errs = 0;
    int checks = 0;

    always #4 clk = ~clk;

    mctimer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cap_in(cap_in), .match_o(match_o), .irq_o(irq_o), .tc_o(tc_o),
        .cap_o(cap_o), .pend_o(pend_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; cap_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk); cap_in = 1'b1;
        repeat (4) @(negedge clk);
        cap_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] prev, e1, e2, ecap;
        int mism;

        // R1 reset state
        do_reset();
        chk("R1 tc", tc_o, 0);
        chk("R1 cap", cap_o, 0);
        chk("R1 pend", {27'd0, pend_o}, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
        chk("R1 match", {28'd0, match_o}, 0);

        // R2 clock counting, then disable
        wr(A_CTRL, 32'h1);
        mism = 0;
        for (int k = 1; k <= 8; k++) begin
            prev = tc_o;
            @(negedge clk);
            if (tc_o != prev + 1) mism++;
        end
        chk("R2 step mismatches", mism, 0);
        chk("R2 value after 8", tc_o, 8);
        wr(A_CTRL, 32'h0);
        prev = tc_o;
        repeat (5) @(negedge clk);
        chk("R2 disabled holds", tc_o, prev);

        // R3 hold forces zero
        wr(A_CTRL, 32'h3);
        repeat (4) @(negedge clk);
        chk("R3 hold zero", tc_o, 0);
        wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        chk("R3 restart from zero", tc_o, 4);

        // R5 R6 compare reset sweep over period
        for (int p = 1; p <= 6; p++) begin
            do_reset();
            wr(A_CMP0, p);
            wr(A_SLOT, 32'h3);
            wr(A_CTRL, 32'h1);
            mism = 0;
            for (int k = 1; k <= 3 * (p + 1); k++) begin
                @(negedge clk);
                if (tc_o != k % (p + 1)) mism++;
            end
            chk("R6 wrap mismatches", mism, 0);
            chk("R5 pend slot0", {27'd0, pend_o}, 1);
        end

        // R7 stop on slot 1, R5 no pending without irq bit
        do_reset();
        wr(A_CMP0 + 4'd1, 5);
        wr(A_SLOT, 32'h20);
        wr(A_CTRL, 32'h1);
        repeat (12) @(negedge clk);
        chk("R7 frozen at compare", tc_o, 5);
        chk("R5 no pend without irq", {27'd0, pend_o}, 0);

        // R4 counter source modes
        for (int m = 1; m <= 3; m++) begin
            do_reset();
            wr(A_SRC, m);
            wr(A_CTRL, 32'h1);
            repeat (5) pulse();
            chk("R4 edge count", tc_o, (m == 3) ? 10 : 5);
        end

        // R8 R9 capture edge selection
        for (int c = 0; c < 3; c++) begin
            logic [2:0] cfg;
            cfg = (c == 0) ? 3'b001 : (c == 1) ? 3'b010 : 3'b111;
            do_reset();
            wr(A_CAPC, cfg);
            wr(A_CTRL, 32'h1);
            repeat (3) @(negedge clk);
            cap_in = 1'b1;
            @(negedge clk); @(negedge clk);
            e1 = tc_o;
            @(negedge clk);
            ecap = cfg[0] ? e1 : 0;
            chk("R8 rising capture", cap_o, ecap);
            repeat (3) @(negedge clk);
            cap_in = 1'b0;
            @(negedge clk); @(negedge clk);
            e2 = tc_o;
            @(negedge clk);
            ecap = cfg[1] ? e2 : ecap;
            chk("R8 falling capture", cap_o, ecap);
            chk("R9 capture pending", {31'd0, pend_o[4]}, {31'd0, cfg[2]});
            chk("R12 irq follows pending", {31'd0, irq_o}, {31'd0, cfg[2]});
        end

        // R10 pin actions
        do_reset();
        for (int i = 0; i < 4; i++) wr(A_CMP0 + 4'(i), 2);
        wr(A_SLOT, 32'h400);
        wr(A_PINS, 32'h3E4);
        chk("R10 direct load", {28'd0, match_o}, 32'h3);
        wr(A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        chk("R10 first event", {28'd0, match_o}, 32'hD);
        repeat (3) @(negedge clk);
        chk("R10 second event", {28'd0, match_o}, 32'h5);

        // R11 PWM duty sweep
        for (int d = 0; d <= 8; d++) begin
            do_reset();
            wr(A_CMP0, 0);
            wr(A_CMP0 + 4'd1, d);
            wr(A_CMP0 + 4'd2, 9);
            wr(A_CMP0 + 4'd3, 7);
            wr(A_PWM, 32'h7);
            wr(A_CTRL, 32'h1);
            mism = 0;
            for (int k = 1; k <= 24; k++) begin
                @(negedge clk);
                if (tc_o != k % 8) mism++;
                if (match_o[0] !== 1'b1) mism++;
                if (match_o[1] !== ((k % 8) >= d)) mism++;
                if (match_o[2] !== 1'b0) mism++;
                if (match_o[3] !== 1'b0) mism++;
            end
            chk("R11 pwm mismatches", mism, 0);
        end

        // R12 clear collides with new event: set wins
        do_reset();
        wr(A_CMP0, 3);
        wr(A_SLOT, 32'h5);
        wr(A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        wr_en = 1'b1; wr_addr = A_IRQ; wr_data = 32'h1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R12 set wins over clear", {27'd0, pend_o}, 1);
        chk("R7 stopped at compare", tc_o, 3);
        wr(A_IRQ, 32'h1);
        chk("R12 cleared", {27'd0, pend_o}, 0);
        chk("R12 irq low", {31'd0, irq_o}, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule